// File: doc/BRIEF.md
# Bridge Over-Current Trip and Fault Latch

This block guards a three-leg power bridge. It watches an over-current comparator flag that is already digital, a flag for undervoltage on the logic supply, and one undervoltage flag for each floating high-side supply. From these it builds a global gate shutdown request, a per-leg high-side kill and an active-low fault enable. The fault enable drives an open-drain pin, so a 0 pulls the line low.

An over-current event counts only when the comparator flag stays high for longer than a blanking window. Any change on any gate command input reopens that window, so switching spikes are filtered out. A trip that passes the filter sets a latch. The latch asserts the fault after `FLT_DLY` cycles and shuts down every gate after `SD_DLY` cycles. The latch releases only when the low-side commands have been held off without a break for `CLR_CYC` cycles. A parameter can also require the high-side commands to be off during that time. Undervoltage does not latch: it acts only while its flag is high.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: While reset is low and no undervoltage flag is set, `fault_n_o` is 1, `sd_all_o` is 0 and `hs_off_o` is all zeros.
- R2: A trip is qualified only when `oc_trip_i` is sampled high on `BLANK_CYC+1` consecutive rising edges and no command input changed in that time. A shorter pulse has no effect on any output.
- R3: A change of any bit of `lo_cmd_n_i` or `hi_cmd_n_i` restarts the blanking count. A trip that overlaps the change must then persist for a full new window.
- R4: The latch sets on the edge that qualifies a trip. `fault_n_o` falls `FLT_DLY` edges later. `sd_all_o` and every bit of `hs_off_o` rise `SD_DLY` edges later.
- R5: The latch holds after the trip flag drops. It clears on the `CLR_CYC`-th consecutive edge on which every `lo_cmd_n_i` bit is 1, which is the off state. A single edge without the condition restarts the count.
- R6: With `CLR_HS`=1, the clear condition also needs every `hi_cmd_n_i` bit to be 1. With `CLR_HS`=0, the high-side commands play no part in clearing.
- R7: A qualified trip during the clear interval aborts the clear. The count then starts again from zero, with the latch still set.
- R8: After the latch clears, `fault_n_o` returns to 1 after `FLT_DLY` edges and `sd_all_o` returns to 0 after `SD_DLY` edges.
- R9: While `uv_logic_i` is 1, `sd_all_o` is 1, `hs_off_o` is all ones and `fault_n_o` is 0, all in the same cycle. Nothing stays set after the flag drops.
- R10: `uv_float_i[k]` sets only `hs_off_o[k]`. It does not change `fault_n_o` or `sd_all_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_trip_i | input | 1 | Over-current comparator flag, already digital |
| uv_logic_i | input | 1 | Logic-supply undervoltage flag |
| uv_float_i | input | NLEG | Floating-supply undervoltage flag, one per leg |
| lo_cmd_n_i | input | NLEG | Low-side gate commands, active low (1 = off) |
| hi_cmd_n_i | input | NLEG | High-side gate commands, active low (1 = off) |
| fault_n_o | output | 1 | Fault enable for an open-drain pin, 0 pulls low |
| sd_all_o | output | 1 | Global shutdown request for all gates |
| hs_off_o | output | NLEG | Per-leg high-side kill |

## Verification
The bench uses `BLANK_CYC`=4, `CLR_CYC`=10, `FLT_DLY`=2 and `SD_DLY`=3. With these values, pulses one cycle either side of the blanking edge can be tried quickly, and an abort placed partway through a clear can be told apart from a normal release within a few cycles. Two copies share the same stimulus, one with `CLR_HS`=0 and one with `CLR_HS`=1. Holding one high-side command on therefore shows the two clearing variants diverging on the same cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic {
    OCP_CLEAR   = 1'b0,
    OCP_TRIPPED = 1'b1
  } ocp_state_e;

  // counter width able to hold the value n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ocp_trip_qual.sv
module ocp_trip_qual
  import ocp_pkg::*;
#(
  parameter int NLEG      = 3,
  parameter int BLANK_CYC = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trip_i,
  input  logic [NLEG-1:0] lo_cmd_n_i,
  input  logic [NLEG-1:0] hi_cmd_n_i,
  output logic            qual_o
);

  localparam int CW  = cnt_w(BLANK_CYC);
  localparam int CMW = 2 * NLEG;

  logic [CW-1:0]  tcnt;
  logic [CMW-1:0] cmd_now, cmd_prev;
  logic           sw_evt;

  assign cmd_now = {hi_cmd_n_i, lo_cmd_n_i};
  assign sw_evt  = (cmd_now != cmd_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_prev <= '1;
      tcnt     <= '0;
    end else begin
      cmd_prev <= cmd_now;
      if (!trip_i || sw_evt)
        tcnt <= '0;
      else if (tcnt != CW'(BLANK_CYC))
        tcnt <= tcnt + 1'b1;
    end
  end

  assign qual_o = trip_i && !sw_evt && (tcnt == CW'(BLANK_CYC));

  generate
    if (BLANK_CYC > 0) begin : g_blank_chk
      assert_qual_after_trip_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> $past(trip_i));
      assert_switch_reblanks_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> !qual_o);
    end
  endgenerate

endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch
  import ocp_pkg::*;
#(
  parameter int NLEG    = 3,
  parameter int CLR_CYC = 850,
  parameter bit CLR_HS  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            qual_i,
  input  logic [NLEG-1:0] lo_cmd_n_i,
  input  logic [NLEG-1:0] hi_cmd_n_i,
  output logic            latched_o
);

  localparam int CW = cnt_w(CLR_CYC);

  // clear condition: all low-side off, high side too when selected
  function automatic logic clear_ok(input logic [NLEG-1:0] lo, input logic [NLEG-1:0] hi);
    return (&lo) && ((&hi) || !CLR_HS);
  endfunction

  ocp_state_e    state;
  logic [CW-1:0] ccnt;
  logic          clr_met;
  logic          clr_last;

  assign clr_met  = clear_ok(lo_cmd_n_i, hi_cmd_n_i);
  assign clr_last = (ccnt == CW'(CLR_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= OCP_CLEAR;
      ccnt  <= '0;
    end else if (qual_i) begin
      state <= OCP_TRIPPED;
      ccnt  <= '0;
    end else if (state == OCP_TRIPPED) begin
      if (!clr_met) begin
        ccnt <= '0;
      end else if (clr_last) begin
        state <= OCP_CLEAR;
        ccnt  <= '0;
      end else begin
        ccnt <= ccnt + 1'b1;
      end
    end
  end

  assign latched_o = (state == OCP_TRIPPED);

  assert_sets_on_qual_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    qual_i |=> latched_o);
  assert_holds_without_clear_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    latched_o && !clr_met |=> latched_o);
  assert_release_needs_clear_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched_o) |-> $past(clr_met) && !$past(qual_i));
  assert_trip_aborts_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    latched_o && qual_i |=> latched_o && (ccnt == '0));

endmodule

// File: rtl/ocp_delay_line.sv
module ocp_delay_line #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [DEPTH-1:0] stage;
      for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            stage[g] <= 1'b0;
          else if (g == 0)
            stage[g] <= din;
          else
            stage[g] <= stage[(g == 0) ? 0 : g - 1];
        end
      end
      assign dout = stage[DEPTH-1];
      if (DEPTH == 1) begin : g_one
        assert_one_cycle_lag_R4 : assert property (@(posedge clk) disable iff (!rst_n)
          din |=> dout);
      end
    end
  endgenerate

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_pkg::*;
#(
  parameter int NLEG      = 3,
  parameter int BLANK_CYC = 40,
  parameter int CLR_CYC   = 850,
  parameter int FLT_DLY   = 55,
  parameter int SD_DLY    = 66,
  parameter bit CLR_HS    = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            oc_trip_i,
  input  logic            uv_logic_i,
  input  logic [NLEG-1:0] uv_float_i,
  input  logic [NLEG-1:0] lo_cmd_n_i,
  input  logic [NLEG-1:0] hi_cmd_n_i,
  output logic            fault_n_o,
  output logic            sd_all_o,
  output logic [NLEG-1:0] hs_off_o
);

  logic trip_qual;
  logic oc_latched;
  logic flt_oc;
  logic sd_oc;

  ocp_trip_qual #(.NLEG(NLEG), .BLANK_CYC(BLANK_CYC)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_i     (oc_trip_i),
    .lo_cmd_n_i (lo_cmd_n_i),
    .hi_cmd_n_i (hi_cmd_n_i),
    .qual_o     (trip_qual)
  );

  ocp_fault_latch #(.NLEG(NLEG), .CLR_CYC(CLR_CYC), .CLR_HS(CLR_HS)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual_i     (trip_qual),
    .lo_cmd_n_i (lo_cmd_n_i),
    .hi_cmd_n_i (hi_cmd_n_i),
    .latched_o  (oc_latched)
  );

  ocp_delay_line #(.DEPTH(FLT_DLY)) u_flt_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (oc_latched),
    .dout  (flt_oc)
  );

  ocp_delay_line #(.DEPTH(SD_DLY)) u_sd_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (oc_latched),
    .dout  (sd_oc)
  );

  assign sd_all_o  = sd_oc | uv_logic_i;
  assign fault_n_o = ~(flt_oc | uv_logic_i);

  generate
    for (genvar k = 0; k < NLEG; k++) begin : g_leg
      assign hs_off_o[k] = sd_all_o | uv_float_i[k];

      assert_float_uv_local_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        uv_float_i[k] |-> hs_off_o[k]);
    end
  endgenerate

  assert_logic_uv_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    uv_logic_i |-> sd_all_o && !fault_n_o && (&hs_off_o));
  assert_quiet_without_cause_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    !uv_logic_i && !oc_latched && !$past(oc_latched) && (FLT_DLY == 1) |-> fault_n_o);

endmodule

// File: tb/test_ocp_fault_ctrl.sv
module test_ocp_fault_ctrl;

  localparam int CLK_P = 10;
  localparam int NLEG  = 3;
  localparam int BLK   = 4;
  localparam int CLR   = 10;
  localparam int FD    = 2;
  localparam int SD    = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trip = 1'b0;
  logic            uv_logic = 1'b0;
  logic [NLEG-1:0] uv_float = '0;
  logic [NLEG-1:0] lo_n = 3'b010;
  logic [NLEG-1:0] hi_n = 3'b111;
  logic            fault_n, sd_all, fault_n_hs, sd_all_hs;
  logic [NLEG-1:0] hs_off, hs_off_hs;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  ocp_fault_ctrl #(.NLEG(NLEG), .BLANK_CYC(BLK), .CLR_CYC(CLR), .FLT_DLY(FD),
                   .SD_DLY(SD), .CLR_HS(1'b0)) i_ocp_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .oc_trip_i(trip), .uv_logic_i(uv_logic),
    .uv_float_i(uv_float), .lo_cmd_n_i(lo_n), .hi_cmd_n_i(hi_n),
    .fault_n_o(fault_n), .sd_all_o(sd_all), .hs_off_o(hs_off));

  ocp_fault_ctrl #(.NLEG(NLEG), .BLANK_CYC(BLK), .CLR_CYC(CLR), .FLT_DLY(FD),
                   .SD_DLY(SD), .CLR_HS(1'b1)) i_ocp_fault_ctrl_hs (
    .clk(clk), .rst_n(rst_n), .oc_trip_i(trip), .uv_logic_i(uv_logic),
    .uv_float_i(uv_float), .lo_cmd_n_i(lo_n), .hi_cmd_n_i(hi_n),
    .fault_n_o(fault_n_hs), .sd_all_o(sd_all_hs), .hs_off_o(hs_off_hs));

  // pulse length, expected fault_n, expected sd_all (sampled 5 cycles after the pulse)
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 0}, '{4, 1, 0}, '{5, 0, 1}, '{6, 0, 1}, '{9, 0, 1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
  endtask

  initial begin
    #(CLK_P * 50000);
    nfail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 fault_n in reset", fault_n, 1);
    chk("R1 sd_all in reset", sd_all, 0);
    chk("R1 hs_off in reset", hs_off, 0);
    rst_n = 1'b1;
    tick(3);

    // R2 table walk: blanking threshold, set and clear per vector
    for (int v = 0; v < NVEC; v++) begin
      trip = 1'b1;
      tick(VEC[v][0]);
      trip = 1'b0;
      tick(5);
      chk($sformatf("R2 fault_n pulse %0d", VEC[v][0]), fault_n, VEC[v][1]);
      chk($sformatf("R2 sd_all pulse %0d", VEC[v][0]), sd_all, VEC[v][2]);
      lo_n = 3'b111;
      tick(CLR + SD + 2);
      chk($sformatf("R8 released after pulse %0d", VEC[v][0]), fault_n, 1);
      lo_n = 3'b010;
      tick(3);
    end

    // R4 timing from the qualifying edge
    trip = 1'b1;
    tick(BLK + 1 + FD - 1);
    chk("R4 fault_n before delay", fault_n, 1);
    tick(1);
    chk("R4 fault_n after delay", fault_n, 0);
    chk("R4 sd_all before delay", sd_all, 0);
    tick(1);
    chk("R4 sd_all after delay", sd_all, 1);
    chk("R4 all high sides off", hs_off, 3'b111);
    trip = 1'b0;
    tick(20);
    chk("R5 latch held with low side on", fault_n, 0);

    // R5 break restarts, R8 release timing
    lo_n = 3'b111;
    tick(6);
    lo_n = 3'b011;
    tick(1);
    lo_n = 3'b111;
    tick(CLR + FD - 1);
    chk("R5 count restarted after break", fault_n, 0);
    tick(1);
    chk("R8 fault_n released", fault_n, 1);
    chk("R8 sd_all still on", sd_all, 1);
    tick(1);
    chk("R8 sd_all released", sd_all, 0);
    lo_n = 3'b010;
    tick(2);

    // R6 high-side participation
    trip = 1'b1;
    tick(6);
    trip = 1'b0;
    tick(4);
    hi_n = 3'b101;
    lo_n = 3'b111;
    tick(CLR + SD + 2);
    chk("R6 CLR_HS=0 clears with high side on", fault_n, 1);
    chk("R6 CLR_HS=1 held with high side on", fault_n_hs, 0);
    hi_n = 3'b111;
    tick(CLR + SD + 2);
    chk("R6 CLR_HS=1 clears with high side off", fault_n_hs, 1);
    lo_n = 3'b010;
    tick(2);

    // R7 abort during clear
    trip = 1'b1;
    tick(6);
    trip = 1'b0;
    tick(4);
    lo_n = 3'b111;
    tick(2);
    trip = 1'b1;
    tick(5);
    trip = 1'b0;
    tick(8);
    chk("R7 fault kept after abort", fault_n, 0);
    chk("R7 shutdown kept after abort", sd_all, 1);
    tick(5);
    chk("R7 fault cleared after full count", fault_n, 1);
    lo_n = 3'b010;
    tick(2);

    // R3 command change restarts blanking
    trip = 1'b1;
    tick(3);
    hi_n = 3'b110;
    tick(5);
    trip = 1'b0;
    tick(5);
    chk("R3 trip ignored across switch", fault_n, 1);
    chk("R3 no shutdown across switch", sd_all, 0);
    hi_n = 3'b111;
    tick(2);
    trip = 1'b1;
    tick(3);
    hi_n = 3'b110;
    tick(6);
    trip = 1'b0;
    tick(4);
    chk("R3 trip qualifies after new window", fault_n, 0);
    hi_n = 3'b111;
    lo_n = 3'b111;
    tick(CLR + SD + 2);
    lo_n = 3'b010;
    tick(2);

    // R9 logic undervoltage
    uv_logic = 1'b1;
    tick(1);
    chk("R9 sd_all on uv", sd_all, 1);
    chk("R9 fault_n on uv", fault_n, 0);
    chk("R9 hs_off on uv", hs_off, 3'b111);
    uv_logic = 1'b0;
    tick(1);
    chk("R9 fault_n not latched", fault_n, 1);
    chk("R9 sd_all not latched", sd_all, 0);

    // R10 floating undervoltage
    uv_float = 3'b010;
    tick(1);
    chk("R10 single leg off", hs_off, 3'b010);
    chk("R10 fault_n untouched", fault_n, 1);
    chk("R10 sd_all untouched", sd_all, 0);
    uv_float = '0;
    tick(1);
    chk("R10 leg restored", hs_off, 0);

    summary();
    $finish;
  end

endmodule